// File: doc/BRIEF.md
# Dual-Lane Condition Compare and Branch Evaluator

This block sits beside the arithmetic path of a vector shader core. On a compare command it orders the x lanes and the y lanes of two 24-bit sign-magnitude float operands. Each lane uses its own relation, and the two outcomes are stored in a two-bit condition register. Bit 0 holds the x result and bit 1 holds the y result.

A purely combinational evaluator reads the stored bits at all times. It matches each bit against a reference value supplied with a flow-control instruction, then joins the two matches under a selected mode. The resulting `taken` signal steers conditional jumps, calls and if-blocks. A start pulse at the beginning of each program run returns both bits to false.

Top module: `ccmp_unit`

## Requirements
- R1: After synchronous active-low reset, `cc` reads 2'b00.
- R2: `run_start` high at a clock edge forces `cc` to 2'b00 after that edge, and it wins over a compare issued in the same cycle.
- R3: With `cmp_valid` high at an edge, `cc[0]` takes the x-lane result (`a_x` versus `b_x`) and `cc[1]` takes the y-lane result (`a_y` versus `b_y`); the new bits are visible after that edge.
- R4: Relation codes on `op_x`/`op_y` are 0 = equal, 1 = not equal, 2 = a less than b, 3 = a less or equal b, 4 = a greater than b, 5 = a greater or equal b.
- R5: Relation codes 6 and 7 leave that lane's bit unchanged, while the other lane still updates.
- R6: Operands use bit 23 as sign (1 = negative) and bits 22:0 as magnitude; every negative non-zero value orders below every positive one, and among negatives the larger magnitude is the smaller value.
- R7: Positive zero (24'h000000) and negative zero (24'h800000) compare equal.
- R8: The evaluator forms mx = (`ref_x` == `cc[0]`) and my = (`ref_y` == `cc[1]`).
- R9: `mode` 0 gives `taken` = mx OR my, 1 gives mx AND my, 2 gives mx alone, 3 gives my alone.
- R10: `taken` depends only on the stored bits, so in the cycle a compare is issued it still reflects the bits from before that compare.
- R11: With `cmp_valid` and `run_start` both low, `cc` holds regardless of the operand and relation inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Clears both condition bits at the start of a run |
| cmp_valid | input | 1 | Issue a compare this cycle |
| op_x | input | 3 | Relation for the x lane |
| op_y | input | 3 | Relation for the y lane |
| a_x | input | 24 | First operand, x lane |
| b_x | input | 24 | Second operand, x lane |
| a_y | input | 24 | First operand, y lane |
| b_y | input | 24 | Second operand, y lane |
| ref_x | input | 1 | Reference value matched against cc[0] |
| ref_y | input | 1 | Reference value matched against cc[1] |
| mode | input | 2 | Join mode for the two matches |
| cc | output | 2 | Stored condition bits |
| taken | output | 1 | Branch condition |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a run-start pulse and a compare command. The bench raises both in one cycle, with relations chosen so that the compare alone would set both bits, and it requires `cc` to read zero afterwards.

The second pair is an evaluation and a compare. The bench holds a compare that flips both bits and samples `taken` before the clock edge; `taken` must match the old bits. After the edge it samples again and requires the flipped result.

// File: rtl/ccmp_pkg.sv
// Shared types and encodings for the dual-lane condition compare unit.
// Assumes 2 lanes (x, y) and 3-bit relation codes; codes 6 and 7 are unused.
package ccmp_pkg;

    localparam int unsigned LANES = 2;
    localparam int unsigned REL_W = 3;

    localparam logic [REL_W-1:0] REL_EQ = 3'd0;
    localparam logic [REL_W-1:0] REL_NE = 3'd1;
    localparam logic [REL_W-1:0] REL_LT = 3'd2;
    localparam logic [REL_W-1:0] REL_LE = 3'd3;
    localparam logic [REL_W-1:0] REL_GT = 3'd4;
    localparam logic [REL_W-1:0] REL_GE = 3'd5;

    typedef enum logic [1:0] {
        JOIN_ANY   = 2'd0,
        JOIN_ALL   = 2'd1,
        JOIN_XONLY = 2'd2,
        JOIN_YONLY = 2'd3
    } join_e;

    typedef struct packed {
        logic lt;
        logic eq;
    } order_t;

endpackage

// File: rtl/ccmp_lane_order.sv
// Orders two sign-magnitude values: reports a<b and a==b.
// Assumes the top bit is the sign and the rest is an ordered magnitude
// (exponent above mantissa); no special encodings. Both zeros are equal.
module ccmp_lane_order
    import ccmp_pkg::*;
#(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output order_t       ord
);
    localparam int unsigned MAG_W = W - 1;

    logic             sign_a, sign_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             both_zero;

    assign sign_a    = a[W-1];
    assign sign_b    = b[W-1];
    assign mag_a     = a[MAG_W-1:0];
    assign mag_b     = b[MAG_W-1:0];
    assign both_zero = (mag_a == '0) && (mag_b == '0);

    // Ordering by sign first, then by magnitude with direction set by sign.
    always_comb begin
        if (both_zero) begin
            ord.lt = 1'b0;
            ord.eq = 1'b1;
        end else if (sign_a != sign_b) begin
            ord.lt = sign_a;
            ord.eq = 1'b0;
        end else if (!sign_a) begin
            ord.lt = (mag_a < mag_b);
            ord.eq = (mag_a == mag_b);
        end else begin
            ord.lt = (mag_a > mag_b);
            ord.eq = (mag_a == mag_b);
        end
    end

    // Less and equal can never both hold for one pair.
    always_comb begin
        assert_order_exclusive_R6: assert (!(ord.lt && ord.eq));
    end

endmodule

// File: rtl/ccmp_rel_select.sv
// Maps an ordering and a relation code to a single condition bit.
// Flags codes outside the six defined relations as not known.
module ccmp_rel_select
    import ccmp_pkg::*;
(
    input  order_t           ord,
    input  logic [REL_W-1:0] rel,
    output logic             hit,
    output logic             known
);
    // Relation decode; unknown codes give known=0 and a don't-care hit of 0.
    always_comb begin
        known = 1'b1;
        unique case (rel)
            REL_EQ:  hit = ord.eq;
            REL_NE:  hit = !ord.eq;
            REL_LT:  hit = ord.lt;
            REL_LE:  hit = ord.lt || ord.eq;
            REL_GT:  hit = !(ord.lt || ord.eq);
            REL_GE:  hit = !ord.lt;
            default: begin
                hit   = 1'b0;
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ccmp_cc_store.sv
// Condition-code register: one bit per lane with its own load enable.
// A clear request overrides every load in the same cycle.
module ccmp_cc_store #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [N-1:0] load,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-lane bit: reset and clear to 0, else load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                q[i] <= 1'b0;
            else if (load[i])
                q[i] <= din[i];
        end

        assert_unloaded_bit_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear && !load[i]) |=> (q[i] == $past(q[i])));
    end

    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q == '0));

endmodule

// File: rtl/ccmp_branch_eval.sv
// Combinational branch condition: matches stored bits against references
// and joins the two matches under the selected mode.
module ccmp_branch_eval
    import ccmp_pkg::*;
(
    input  logic [1:0] cc,
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic [1:0] mode,
    output logic       taken
);
    logic mx, my;

    assign mx = (ref_x == cc[0]);
    assign my = (ref_y == cc[1]);

    // Join the per-lane matches.
    always_comb begin
        unique case (join_e'(mode))
            JOIN_ANY:   taken = mx || my;
            JOIN_ALL:   taken = mx && my;
            JOIN_XONLY: taken = mx;
            default:    taken = my;
        endcase
    end

endmodule

// File: rtl/ccmp_unit.sv
// Dual-lane condition compare and branch evaluator (top).
// Each lane is ordered, decoded under its own relation and stored as one
// condition bit; a start pulse clears both; taken is read from stored bits.
module ccmp_unit
    import ccmp_pkg::*;
#(
    parameter int unsigned W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_start,
    input  logic             cmp_valid,
    input  logic [REL_W-1:0] op_x,
    input  logic [REL_W-1:0] op_y,
    input  logic [W-1:0]     a_x,
    input  logic [W-1:0]     b_x,
    input  logic [W-1:0]     a_y,
    input  logic [W-1:0]     b_y,
    input  logic             ref_x,
    input  logic             ref_y,
    input  logic [1:0]       mode,
    output logic [LANES-1:0] cc,
    output logic             taken
);
    logic [W-1:0]     lane_a   [LANES];
    logic [W-1:0]     lane_b   [LANES];
    logic [REL_W-1:0] lane_rel [LANES];
    order_t           lane_ord [LANES];
    logic [LANES-1:0] lane_hit, lane_known, lane_load;

    assign lane_a[0]   = a_x;
    assign lane_a[1]   = a_y;
    assign lane_b[0]   = b_x;
    assign lane_b[1]   = b_y;
    assign lane_rel[0] = op_x;
    assign lane_rel[1] = op_y;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ccmp_lane_order #(.W(W)) i_order (
            .a   (lane_a[i]),
            .b   (lane_b[i]),
            .ord (lane_ord[i])
        );

        ccmp_rel_select i_sel (
            .ord   (lane_ord[i]),
            .rel   (lane_rel[i]),
            .hit   (lane_hit[i]),
            .known (lane_known[i])
        );

        assign lane_load[i] = cmp_valid && lane_known[i];
    end

    ccmp_cc_store #(.N(LANES)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (run_start),
        .load  (lane_load),
        .din   (lane_hit),
        .q     (cc)
    );

    ccmp_branch_eval i_eval (
        .cc    (cc),
        .ref_x (ref_x),
        .ref_y (ref_y),
        .mode  (mode),
        .taken (taken)
    );

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !run_start) |=> $stable(cc));

    assert_unknown_x_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !run_start && (op_x > REL_GE)) |=> (cc[0] == $past(cc[0])));

    assert_zero_pair_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !run_start && (op_x == REL_EQ)
         && (a_x[W-2:0] == '0) && (b_x[W-2:0] == '0)) |=> cc[0]);

    assert_all_mode_needs_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1) && taken) |-> ((ref_x == cc[0]) && (ref_y == cc[1])));

    assert_any_mode_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0) && !taken) |-> ((ref_x != cc[0]) && (ref_y != cc[1])));

endmodule

// File: tb/test_ccmp_unit.sv
// Directed bench for ccmp_unit: one task per scenario, each checking itself.
module test_ccmp_unit;

    localparam logic [23:0] P1 = 24'h3F0000;
    localparam logic [23:0] P2 = 24'h400000;
    localparam logic [23:0] N1 = 24'hBF0000;
    localparam logic [23:0] N2 = 24'hC00000;
    localparam logic [23:0] PZ = 24'h000000;
    localparam logic [23:0] NZ = 24'h800000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_start = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [2:0]  op_x = 3'd0, op_y = 3'd0;
    logic [23:0] a_x = '0, b_x = '0, a_y = '0, b_y = '0;
    logic        ref_x = 1'b0, ref_y = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  cc;
    logic        taken;

    int total = 0;
    int bad   = 0;
    logic [1:0] exp_cc = 2'b00;

    always #2 clk = ~clk;

    ccmp_unit i_ccmp_unit (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .cmp_valid(cmp_valid),
        .op_x(op_x), .op_y(op_y), .a_x(a_x), .b_x(b_x), .a_y(a_y), .b_y(b_y),
        .ref_x(ref_x), .ref_y(ref_y), .mode(mode), .cc(cc), .taken(taken)
    );

    function automatic int sval(input logic [23:0] v);
        int m;
        m = int'(v[22:0]);
        return v[23] ? -m : m;
    endfunction

    // Returns 0/1 for a defined relation, 2 for an unknown code.
    function automatic int rel_ref(input logic [2:0] op, input logic [23:0] a, input logic [23:0] b);
        int x, y;
        x = sval(a);
        y = sval(b);
        case (op)
            3'd0: return int'(x == y);
            3'd1: return int'(x != y);
            3'd2: return int'(x < y);
            3'd3: return int'(x <= y);
            3'd4: return int'(x > y);
            3'd5: return int'(x >= y);
            default: return 2;
        endcase
    endfunction

    function automatic logic taken_ref(input logic [1:0] c, input logic rx, input logic ry, input logic [1:0] md);
        logic mx, my;
        mx = (rx == c[0]);
        my = (ry == c[1]);
        case (md)
            2'd0: return mx | my;
            2'd1: return mx & my;
            2'd2: return mx;
            default: return my;
        endcase
    endfunction

    task automatic chk(input string req, input int got, input int expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", req, got, expv);
        end
    endtask

    // One compare cycle; updates the expected bits from the reference model.
    task automatic cmp_step(input logic [2:0] ox, input logic [23:0] ax, input logic [23:0] bx,
                            input logic [2:0] oy, input logic [23:0] ay, input logic [23:0] by,
                            input logic start);
        int rx, ry;
        @(negedge clk);
        op_x = ox; a_x = ax; b_x = bx;
        op_y = oy; a_y = ay; b_y = by;
        cmp_valid = 1'b1;
        run_start = start;
        @(negedge clk);
        cmp_valid = 1'b0;
        run_start = 1'b0;
        rx = rel_ref(ox, ax, bx);
        ry = rel_ref(oy, ay, by);
        if (start) exp_cc = 2'b00;
        else begin
            if (rx != 2) exp_cc[0] = rx[0];
            if (ry != 2) exp_cc[1] = ry[0];
        end
    endtask

    task automatic set_cc(input logic [1:0] v);
        cmp_step(v[0] ? 3'd0 : 3'd1, P1, P1, v[1] ? 3'd0 : 3'd1, P1, P1, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 cc after reset", int'(cc), 0);
    endtask

    task automatic t_relations;
        logic [23:0] pa [3] = '{P1, P2, P1};
        logic [23:0] pb [3] = '{P2, P1, P1};
        for (int op = 0; op < 6; op++) begin
            for (int k = 0; k < 3; k++) begin
                cmp_step(3'(op), pa[k], pb[k], 3'(5 - op), pb[k], pa[k], 1'b0);
                chk("R4 R3 relation result", int'(cc), int'(exp_cc));
            end
        end
    endtask

    task automatic t_signs;
        cmp_step(3'd2, N1, P1, 3'd2, N2, N1, 1'b0);
        chk("R6 negative below positive / larger negative smaller", int'(cc), 2'b11);
        cmp_step(3'd4, N1, N2, 3'd2, P1, N1, 1'b0);
        chk("R6 mixed signs", int'(cc), 2'b01);
        cmp_step(3'd3, NZ, P1, 3'd4, PZ, N1, 1'b0);
        chk("R6 zero against signed values", int'(cc), 2'b11);
    endtask

    task automatic t_zero;
        cmp_step(3'd0, PZ, NZ, 3'd1, NZ, PZ, 1'b0);
        chk("R7 +0 equals -0", int'(cc), 2'b01);
        cmp_step(3'd2, NZ, PZ, 3'd5, PZ, NZ, 1'b0);
        chk("R7 -0 not below +0", int'(cc), 2'b10);
    endtask

    task automatic t_unknown;
        set_cc(2'b01);
        cmp_step(3'd6, P2, P1, 3'd0, P1, P1, 1'b0);
        chk("R5 code 6 keeps x, y updates", int'(cc), 2'b11);
        set_cc(2'b10);
        cmp_step(3'd0, P1, P1, 3'd7, P1, P2, 1'b0);
        chk("R5 code 7 keeps y, x updates", int'(cc), 2'b11);
        cmp_step(3'd7, P1, P2, 3'd6, P2, P1, 1'b0);
        chk("R5 both unknown keep both", int'(cc), 2'b11);
    endtask

    task automatic t_hold;
        set_cc(2'b10);
        @(negedge clk);
        op_x = 3'd0; a_x = P1; b_x = P1;
        op_y = 3'd1; a_y = P1; b_y = P1;
        repeat (3) @(negedge clk);
        chk("R11 no compare holds cc", int'(cc), 2'b10);
    endtask

    task automatic t_eval;
        for (int v = 0; v < 4; v++) begin
            set_cc(2'(v));
            for (int r = 0; r < 4; r++) begin
                for (int m = 0; m < 4; m++) begin
                    @(negedge clk);
                    ref_x = r[0]; ref_y = r[1]; mode = 2'(m);
                    #1;
                    chk("R8 R9 taken", int'(taken), int'(taken_ref(2'(v), r[0], r[1], 2'(m))));
                end
            end
        end
    endtask

    task automatic t_start;
        set_cc(2'b11);
        @(negedge clk);
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
        exp_cc = 2'b00;
        chk("R2 start clears", int'(cc), 0);
        cmp_step(3'd0, P1, P1, 3'd0, P1, P1, 1'b1);
        chk("R2 start wins over same-cycle compare", int'(cc), 0);
    endtask

    task automatic t_timing;
        set_cc(2'b00);
        @(negedge clk);
        ref_x = 1'b1; ref_y = 1'b1; mode = 2'd1;
        op_x = 3'd0; a_x = P1; b_x = P1;
        op_y = 3'd0; a_y = P2; b_y = P2;
        cmp_valid = 1'b1;
        #1;
        chk("R10 taken from old bits during compare", int'(taken), 0);
        @(negedge clk);
        cmp_valid = 1'b0;
        exp_cc = 2'b11;
        chk("R10 taken after compare", int'(taken), 1);
        chk("R3 both lanes stored", int'(cc), 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_relations();
        t_signs();
        t_zero();
        t_unknown();
        t_hold();
        t_eval();
        t_start();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule